// File: doc/BRIEF.md
# Fixed-Point Affine Color Matrix

This block maps a three-component pixel (for example luma plus two chroma components) into another three-component space (for example RGB). It applies a programmable 3x4 affine matrix: each output component is the sum of three signed products of the input components with matrix factors, plus a signed offset. The result is then rounded and saturated back to an unsigned 8-bit component. Pixels arrive one per clock over a valid/ready stream and leave through a fixed two-stage pipeline.

Twelve signed 20-bit matrix words and one control word are loaded through a plain write strobe with an address. Bit 0 of the control word enables the conversion. While it is clear, pixels travel through the same two stages unchanged.

Stream rules: a pixel is taken when `in_valid` and `in_ready` are both high at a rising edge, and it is delivered when `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being emptied in that cycle. When the output is held by a low `out_ready`, both pipeline stages freeze together. The output pixel and its valid flag stay unchanged until the consumer takes them.

Top module: `color_affine_xform`

## Requirements
- R1: During and directly after reset, `out_valid` is low and `in_ready` is high. Every matrix word is zero and the enable is clear, so pixels pass through unchanged until the block is programmed.
- R2: A pixel accepted at one rising edge appears on `out_pix` with `out_valid` high after the second advancing edge. An advancing edge is one where the output is empty or is being taken.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` keeps its value on the following cycle.
- R4: With the enable set, output component r equals floor((m[4r]*p0 + m[4r+1]*p1 + m[4r+2]*p2 + m[4r+3] + 512) / 1024). Here p0 = `in_pix[7:0]`, p1 = `in_pix[15:8]` and p2 = `in_pix[23:16]`, each unsigned. Every m is a signed 20-bit value with 10 fractional bits, and the offset m[4r+3] is in the same units as a product. Component r is placed at `out_pix[8r+7:8r]`.
- R5: A component whose rounded value is negative is output as 0.
- R6: A component whose rounded value exceeds 255 is output as 255.
- R7: With the enable clear, `out_pix` equals the accepted `in_pix`, with the same latency as the converted path.
- R8: A write with `wr_en` high and `wr_addr` = 4r+c (r in 0..2, c in 0..3) loads `wr_data` into matrix word 4r+c. Columns c = 0..2 are the factors for components 0..2, and c = 3 is the row offset.
- R9: A write to address 12 loads the enable from `wr_data[0]`. Any write affects only pixels accepted at later edges. A pixel accepted at the same edge as a write uses the values held before that write.
- R10: Writes to addresses 13, 14 and 15 change neither the matrix nor the enable.
- R11: `in_ready` equals `!out_valid || out_ready`. Pixels leave in acceptance order, with none dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pix | input | 24 | Input pixel, component 0 in the low byte |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | 24 | Output pixel, row 0 result in the low byte |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address: 0..11 matrix, 12 control |
| wr_data | input | 20 | Write data, signed matrix word or enable in bit 0 |

## Verification
The bench goes after rounding at exact half steps. A design that truncated instead of adding half an LSB would output values one lower at odd multiples of 0.5. It drives offsets and factors far enough to push sums below zero and above 255. A design that wrapped instead of saturating would show low bytes of the overflowed sums there.

The bench also interleaves register writes with accepted pixels in the same cycle, including writes to the three unused addresses. A design that let a write reach the pixel taken at that edge, or decoded the spare addresses onto real words, would mismatch the reference model for those pixels. Random consumer stalls test that the two stages freeze together: a design with a stage that kept moving would lose or repeat pixels.

// File: rtl/cax_pkg.sv
package cax_pkg;
  localparam int unsigned NCOMP    = 3;
  localparam int unsigned NCOL     = NCOMP + 1;
  localparam int unsigned NWORD    = NCOMP * NCOL;
  localparam int unsigned CTRL_IDX = NWORD;
endpackage

// File: rtl/cax_coef_bank.sv
module cax_coef_bank
  import cax_pkg::*;
#(
  parameter int unsigned COEF_W = 20,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [COEF_W-1:0]         wr_data,
  output logic [NWORD*COEF_W-1:0]   coef_flat,
  output logic                      xform_en
);
  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic [COEF_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(w))
        word_q <= wr_data;
    end
    assign coef_flat[w*COEF_W +: COEF_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      xform_en <= 1'b0;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_IDX))
      xform_en <= wr_data[0];
  end
endmodule

// File: rtl/cax_dot.sv
module cax_dot
  import cax_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 20,
  parameter int unsigned ACC_W  = COEF_W + PIX_W + 3
) (
  input  logic [NCOMP*PIX_W-1:0]   pix,
  input  logic [NCOL*COEF_W-1:0]   row_coef,
  output logic signed [ACC_W-1:0]  acc
);
  logic signed [COEF_W-1:0] offset_s;
  assign offset_s = signed'(row_coef[NCOMP*COEF_W +: COEF_W]);

  always_comb begin
    logic signed [ACC_W-1:0] sum;
    sum = ACC_W'(offset_s);
    for (int j = 0; j < NCOMP; j++) begin
      logic signed [PIX_W:0]    p_s;
      logic signed [COEF_W-1:0] c_s;
      p_s = signed'({1'b0, pix[j*PIX_W +: PIX_W]});
      c_s = signed'(row_coef[j*COEF_W +: COEF_W]);
      sum = sum + ACC_W'(p_s) * ACC_W'(c_s);
    end
    acc = sum;
  end
endmodule

// File: rtl/cax_quant.sv
module cax_quant #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned FRAC  = 10,
  parameter int unsigned ACC_W = 31
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic [PIX_W-1:0]        comp
);
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] rounded;
  logic signed [ACC_W-1:0] whole;

  assign rounded = acc + HALF;
  assign whole   = rounded >>> FRAC;

  always_comb begin
    if (whole < 0)
      comp = '0;
    else if (whole > PIX_MAX)
      comp = '1;
    else
      comp = whole[PIX_W-1:0];
  end
endmodule

// File: rtl/color_affine_xform.sv
module color_affine_xform
  import cax_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 20,
  parameter int unsigned FRAC   = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NCOMP*PIX_W-1:0]   in_pix,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NCOMP*PIX_W-1:0]   out_pix,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [COEF_W-1:0]        wr_data
);
  localparam int unsigned ACC_W = COEF_W + PIX_W + 3;
  localparam int unsigned PXL_W = NCOMP * PIX_W;
  localparam int unsigned ROW_W = NCOL * COEF_W;

  logic [NWORD*COEF_W-1:0] coef_flat;
  logic                    xform_en;
  logic                    advance;

  logic                    s1_valid;
  logic                    s1_en;
  logic [PXL_W-1:0]        s1_pix;
  logic [PXL_W-1:0]        conv_pix;

  cax_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .coef_flat (coef_flat),
    .xform_en  (xform_en)
  );

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  for (genvar r = 0; r < NCOMP; r++) begin : g_row
    logic signed [ACC_W-1:0] acc_c;
    logic signed [ACC_W-1:0] acc_q;

    cax_dot #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) i_dot (
      .pix      (in_pix),
      .row_coef (coef_flat[r*ROW_W +: ROW_W]),
      .acc      (acc_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        acc_q <= '0;
      else if (advance && in_valid)
        acc_q <= acc_c;
    end

    cax_quant #(.PIX_W(PIX_W), .FRAC(FRAC), .ACC_W(ACC_W)) i_quant (
      .acc  (acc_q),
      .comp (conv_pix[r*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_en    <= 1'b0;
      s1_pix   <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_en  <= xform_en;
        s1_pix <= in_pix;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid)
        out_pix <= s1_en ? conv_pix : s1_pix;
    end
  end
endmodule

// File: rtl/cax_chk.sv
module cax_chk
  import cax_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 20,
  parameter int unsigned ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [NCOMP*PIX_W-1:0]  out_pix,
  input logic                    s1_valid,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [COEF_W-1:0]       wr_data,
  input logic [NWORD*COEF_W-1:0] coef_flat,
  input logic                    xform_en
);
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !s1_valid);

  a_r2_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && in_ready |=> out_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  a_r11_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  for (genvar w = 0; w < NWORD; w++) begin : g_wchk
    a_r8_word_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == ADDR_W'(w) |=> coef_flat[w*COEF_W +: COEF_W] == $past(wr_data));
  end

  a_r9_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == ADDR_W'(CTRL_IDX) |=> xform_en == $past(wr_data[0]));

  a_r10_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr > ADDR_W'(CTRL_IDX) |=> $stable(coef_flat) && $stable(xform_en));
endmodule

bind color_affine_xform cax_chk #(
  .PIX_W(PIX_W), .COEF_W(COEF_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .s1_valid  (s1_valid),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .coef_flat (coef_flat),
  .xform_en  (xform_en)
);

// File: tb/test_color_affine_xform.sv
`timescale 1ns/1ps
module test_color_affine_xform;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pix = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_pix;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [19:0] wr_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int     mc[12];
  bit     men = 1'b0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  bit          hold_pending = 1'b0;
  logic [23:0] hold_pix;

  always #2 clk = ~clk;

  color_affine_xform i_color_affine_xform (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [23:0] p, output logic [23:0] o,
                                output string tag);
    bit lo = 0, hi = 0;
    if (!men) begin
      o = p; tag = "R7"; return;
    end
    for (int r = 0; r < 3; r++) begin
      longint acc = longint'(mc[4*r+3]);
      longint v;
      for (int c = 0; c < 3; c++)
        acc += longint'(mc[4*r+c]) * longint'(p[8*c +: 8]);
      v = (acc + 512) >>> 10;
      if (v < 0) begin v = 0; lo = 1; end
      else if (v > 255) begin v = 255; hi = 1; end
      o[8*r +: 8] = v[7:0];
    end
    tag = lo ? "R5" : (hi ? "R6" : "R4");
  endfunction

  task automatic evaluate();
    check(in_ready === (!out_valid || out_ready), "R11", "in_ready rule",
          in_ready, !out_valid || out_ready);
    if (hold_pending)
      check(out_valid === 1'b1 && out_pix === hold_pix, "R3", "held output",
            out_pix, hold_pix);
    hold_pending = out_valid && !out_ready;
    hold_pix = out_pix;
    if (out_valid) begin
      check(exp_q.size() > 0, "R11", "output without pending pixel",
            exp_q.size(), 1);
      if (out_ready && exp_q.size() > 0) begin
        logic [23:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        check(out_pix === e, t, "converted pixel (R2 latency)", out_pix, e);
      end
    end
    if (in_valid && in_ready) begin
      logic [23:0] e;
      string t;
      model(in_pix, e, t);
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    if (wr_en) begin
      if (wr_addr < 12) mc[wr_addr] = $signed(wr_data);
      else if (wr_addr == 12) men = wr_data[0];
    end
  endtask

  task automatic step(input bit iv, input logic [23:0] ip, input bit ordy,
                      input bit we, input logic [3:0] wa, input logic [19:0] wd);
    @(negedge clk);
    in_valid = iv; in_pix = ip; out_ready = ordy;
    wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    evaluate();
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    step(1'b0, '0, 1'b1, 1'b1, a, d[19:0]);
  endtask

  task automatic load_matrix(input int m[12]);
    for (int i = 0; i < 12; i++) wr(4'(i), m[i]);
  endtask

  task automatic stream(input int n, input int stall_pct, input int wr_pct);
    for (int i = 0; i < n; i++) begin
      bit iv = ($urandom_range(99) < 80);
      bit ordy = ($urandom_range(99) >= stall_pct);
      bit we = ($urandom_range(99) < wr_pct);
      step(iv, 24'($urandom), ordy, we, 4'($urandom_range(15)),
           20'($urandom_range(4095)) - 20'd2048);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && (exp_q.size() > 0 || out_valid); i++)
      step(1'b0, '0, 1'b1, 1'b0, '0, '0);
  endtask

  initial begin
    int mtx[12];
    for (int i = 0; i < 12; i++) mc[i] = 0;
    @(negedge clk); #1;
    check(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready === 1'b1, "R1", "in_ready in reset", in_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R1/R7: unprogrammed block passes pixels through
    for (int i = 0; i < 20; i++) step(1'b1, 24'($urandom), 1'b1, 1'b0, '0, '0);
    drain();

    // R8/R4: identity matrix, enable on
    mtx = '{1024, 0, 0, 0,  0, 1024, 0, 0,  0, 0, 1024, 0};
    load_matrix(mtx);
    wr(4'd12, 1);
    stream(40, 30, 0);
    drain();

    // R4 rounding at half steps
    mtx = '{512, 0, 0, 0,  0, 512, 0, 1536,  0, 0, 1536, -512};
    load_matrix(mtx);
    for (int i = 0; i < 12; i++)
      step(1'b1, {8'(i), 8'(i + 1), 8'(2 * i + 1)}, 1'b1, 1'b0, '0, '0);
    drain();

    // R5/R6: colour-like matrix with strong offsets
    mtx = '{1192, 0, 1634, -228262,  1192, -401, -833, 138740,
            1192, 2067, 0, -283062};
    load_matrix(mtx);
    stream(200, 40, 0);
    drain();
    mtx = '{-3000, 0, 0, 0,  4000, 0, 0, 0,  0, 0, 0, 300000};
    load_matrix(mtx);
    stream(40, 20, 0);
    drain();

    // R10: spare addresses must not disturb state
    wr(4'd12, 0);
    wr(4'd13, 20'hFFFFF);
    wr(4'd14, 20'hFFFFF);
    wr(4'd15, 20'hFFFFF);
    for (int i = 0; i < 8; i++) step(1'b1, 24'($urandom), 1'b1, 1'b0, '0, '0);
    drain();

    // R9/R10/R11: writes interleaved with traffic and random stalls
    stream(3000, 35, 40);
    drain();

    check(exp_q.size() == 0, "R11", "pixels left undelivered", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule